// File: doc/BRIEF.md
# Half-Integer and M/N Fractional Enable Divider

This block turns a single input clock into a stream of one-cycle enable pulses whose average rate is a programmable fraction of the clock rate. Everything stays in one clock domain, so downstream logic gates its work with the enable instead of receiving a derived clock. The rate is set in two cascaded stages. The first is a pre-divider whose field holds twice the wanted ratio minus one, which makes ratios in steps of one half possible. The second is an optional M/N stage that lets through m of every n pulses coming from the pre-divider.

The configuration is presented on input buses and captured only when the load strobe is high. M is given directly. N and D are given in inverted form: the N input holds the bitwise inverse of (n - m), and the D input holds the bitwise inverse of n, both cut to the counter width. The block recovers n from the N input and m, and compares the captured D input against that n, flagging any disagreement. D plays no part in pulse generation.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held, pulse_o is 0. After reset the captured configuration is divider 0 with the M/N stage bypassed, so pulse_o is 1 in every cycle before the first load.
- R2: A captured divider field of 0 or 1 gives one pre-divided pulse in every cycle.
- R3: A captured divider field d of 2 or more gives floor(2·T/(d+1)) pre-divided pulses over the first T cycles after a load. For example, d=2 gives 2 pulses in every 3 cycles and d=31 gives 1 pulse in every 16 cycles.
- R4: The decoded n is the bitwise inverse of the N input, cut to MND_W bits, plus m. The sum is formed at MND_W+1 bits, so n can reach 2·(2^MND_W−1).
- R5: The M/N stage is active when the mode input is any nonzero value, n is nonzero and m differs from n. Then P pre-divided pulses give floor(m·P/n) output pulses, counted from a load. With m=0 no pulses come out.
- R6: With mode 0, with m equal to n (N input all ones), or with n equal to 0, the M/N stage is bypassed and every pre-divided pulse appears on pulse_o.
- R7: In the cycle after a load strobe, pulse_o is 0 and both accumulators restart from zero. Configuration inputs that change without a load strobe do not affect pulse_o.
- R8: While the M/N stage is active, each group of n consecutive pre-divided pulses after a load yields exactly m output pulses.
- R9: d_err_o is 1 exactly when the captured D input differs from the bitwise inverse of the low MND_W bits of the decoded n.
- R10: pulse_o follows a pre-divided pulse by one clock cycle. The cycle in which the load is sampled never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_load | input | 1 | Capture strobe for the configuration inputs |
| cfg_div | input | DIV_W | Pre-divider field, twice the ratio minus one |
| cfg_mode | input | 2 | M/N stage request, any nonzero value enables it |
| cfg_m | input | MND_W | M value |
| cfg_n_inv | input | MND_W | Inverse of (n - m) |
| cfg_d_inv | input | MND_W | Inverse of n, checked only |
| pulse_o | output | 1 | One-cycle enable pulse stream |
| d_err_o | output | 1 | Captured D disagrees with decoded n |

## Verification
The assertions rely on the configuration changing only through the load strobe, and on the divider and M/N values being read from the captured copy. The pulse-window check in particular relies on the accumulators starting from zero at each load. The stimulus changes the configuration inputs only on the falling edge and samples outputs there as well. Each setting is applied with one load pulse, followed by a free-running window that is long enough to hold whole M/N groups. The one test that changes the inputs without a load uses a setting whose output does not depend on the accumulator phase, so the expected count is exact.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    MN_BYPASS = 1'b0,
    MN_ACTIVE = 1'b1
  } mn_sel_e;
endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
  import fdiv_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       mode_i,
  input  logic [MND_W-1:0] m_i,
  input  logic [MND_W-1:0] ninv_i,
  input  logic [MND_W-1:0] dinv_i,
  output logic [DIV_W-1:0] div_o,
  output logic [MND_W-1:0] m_o,
  output logic [MND_W:0]   n_o,
  output mn_sel_e          sel_o,
  output logic             d_err_o
);
  localparam int NW = MND_W + 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [1:0]       mode_q, mode_d;
  logic [MND_W-1:0] m_q, m_d, ninv_q, ninv_d, dinv_q, dinv_d;
  logic [NW-1:0]    n_dec;

  always_comb begin
    div_d  = div_q;
    mode_d = mode_q;
    m_d    = m_q;
    ninv_d = ninv_q;
    dinv_d = dinv_q;
    if (load_i) begin
      div_d  = div_i;
      mode_d = mode_i;
      m_d    = m_i;
      ninv_d = ninv_i;
      dinv_d = dinv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= '0;
      m_q    <= '0;
      ninv_q <= '0;
      dinv_q <= '0;
    end else begin
      div_q  <= div_d;
      mode_q <= mode_d;
      m_q    <= m_d;
      ninv_q <= ninv_d;
      dinv_q <= dinv_d;
    end
  end

  always_comb begin
    n_dec   = {1'b0, ~ninv_q} + {1'b0, m_q};
    sel_o   = ((mode_q != 2'd0) && (n_dec != '0) && ({1'b0, m_q} != n_dec))
              ? MN_ACTIVE : MN_BYPASS;
    d_err_o = (dinv_q != ~n_dec[MND_W-1:0]);
    div_o   = div_q;
    m_o     = m_q;
    n_o     = n_dec;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(div_o) && $stable(m_o) && $stable(n_o))); // R7
endmodule

// File: rtl/fdiv_pre.sv
module fdiv_pre #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pre_o
);
  localparam int AW = DIV_W + 1;

  logic [AW-1:0] acc_q, acc_d, sum, lim;

  always_comb begin
    sum   = acc_q + AW'(2);
    lim   = {1'b0, div_i} + AW'(1);
    pre_o = 1'b0;
    acc_d = acc_q;
    if (div_i < DIV_W'(2)) begin
      pre_o = 1'b1;
      acc_d = '0;
    end else if (sum >= lim) begin
      pre_o = 1'b1;
      acc_d = sum - lim;
    end else begin
      acc_d = sum;
    end
    if (clr_i) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i >= DIV_W'(2)) |-> (acc_q < lim)); // R3
endmodule

// File: rtl/fdiv_mn.sv
module fdiv_mn
  import fdiv_pkg::*;
#(
  parameter int MND_W  = 8,
  parameter bit HAS_MN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pre_i,
  input  mn_sel_e          sel_i,
  input  logic [MND_W-1:0] m_i,
  input  logic [MND_W:0]   n_i,
  output logic             pulse_o
);
  localparam int NW = MND_W + 1;
  localparam int SW = MND_W + 2;

  logic fire;
  logic out_q, out_d;

  generate
    if (HAS_MN) begin : g_mn
      logic [NW-1:0] acc_q;
      logic [SW-1:0] sum, acc_d;
      logic          hit;
      logic [NW-1:0] win_pre_q, win_pre_d, win_out_q, win_out_d;
      logic          act_pre;

      always_comb begin
        sum     = {1'b0, acc_q} + SW'(m_i);
        hit     = 1'b0;
        acc_d   = {1'b0, acc_q};
        act_pre = (sel_i == MN_ACTIVE) && pre_i;
        if (act_pre) begin
          if (sum >= SW'(n_i)) begin
            hit   = 1'b1;
            acc_d = sum - SW'(n_i);
          end else begin
            acc_d = sum;
          end
        end
        if (clr_i) acc_d = '0;
        fire = (sel_i == MN_ACTIVE) ? hit : pre_i;
      end

      // window bookkeeping used only by the group check below
      always_comb begin
        win_pre_d = win_pre_q;
        win_out_d = win_out_q;
        if (act_pre) begin
          if (win_pre_q == n_i - NW'(1)) begin
            win_pre_d = '0;
            win_out_d = '0;
          end else begin
            win_pre_d = win_pre_q + NW'(1);
            win_out_d = win_out_q + NW'(hit);
          end
        end
        if (clr_i) begin
          win_pre_d = '0;
          win_out_d = '0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q     <= '0;
          win_pre_q <= '0;
          win_out_q <= '0;
        end else begin
          acc_q     <= acc_d[NW-1:0];
          win_pre_q <= win_pre_d;
          win_out_q <= win_out_d;
        end
      end

      AST_MN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == MN_ACTIVE) |-> (acc_q < n_i)); // R5

      AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pre && !clr_i && (win_pre_q == n_i - NW'(1)))
          |-> ((win_out_q + NW'(hit)) == NW'(m_i))); // R8
    end else begin : g_bypass
      always_comb fire = pre_i;
    end
  endgenerate

  always_comb out_d = clr_i ? 1'b0 : fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pulse_o = out_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int MND_W  = 8,
  parameter bit HAS_MN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_mode,
  input  logic [MND_W-1:0] cfg_m,
  input  logic [MND_W-1:0] cfg_n_inv,
  input  logic [MND_W-1:0] cfg_d_inv,
  output logic             pulse_o,
  output logic             d_err_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_q;
  logic [MND_W-1:0] m_q;
  logic [MND_W:0]   n_q;
  mn_sel_e          mn_sel;
  logic             pre_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fdiv_cfg #(.DIV_W(DIV_W), .MND_W(MND_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (cfg_load),
    .div_i   (cfg_div),
    .mode_i  (cfg_mode),
    .m_i     (cfg_m),
    .ninv_i  (cfg_n_inv),
    .dinv_i  (cfg_d_inv),
    .div_o   (div_q),
    .m_o     (m_q),
    .n_o     (n_q),
    .sel_o   (mn_sel),
    .d_err_o (d_err_o)
  );

  fdiv_pre #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (cfg_load),
    .div_i (div_q),
    .pre_o (pre_pulse)
  );

  fdiv_mn #(.MND_W(MND_W), .HAS_MN(HAS_MN)) u_mn (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (cfg_load),
    .pre_i   (pre_pulse),
    .sel_i   (mn_sel),
    .m_i     (m_q),
    .n_i     (n_q),
    .pulse_o (pulse_o)
  );

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_load |=> !pulse_o); // R7

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg_load && (div_q < DIV_W'(2)) && (mn_sel == MN_BYPASS)) |=> pulse_o); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg_load && (mn_sel == MN_BYPASS)) |=> (pulse_o == $past(pre_pulse))); // R6
endmodule

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_load;
  logic [DIV_W-1:0] cfg_div;
  logic [1:0]       cfg_mode;
  logic [MND_W-1:0] cfg_m, cfg_n_inv, cfg_d_inv;
  logic             pulse_o, d_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  frac_clk_div #(.DIV_W(DIV_W), .MND_W(MND_W), .HAS_MN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
    .cfg_mode(cfg_mode), .cfg_m(cfg_m), .cfg_n_inv(cfg_n_inv),
    .cfg_d_inv(cfg_d_inv), .pulse_o(pulse_o), .d_err_o(d_err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_div = '0; cfg_mode = '0;
    cfg_m = '0; cfg_n_inv = '0; cfg_d_inv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pulse", int'(pulse_o), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      check("R1 default rate", int'(pulse_o), 1);
    end
  endtask

  task automatic run_case(input string tag, input int dv, input int md,
                          input int mm, input int ninv, input int dinv, input int t);
    int n, p, expv, cnt, derr;
    bit act;
    n    = ((~ninv) & 255) + mm;
    act  = (md != 0) && (n != 0) && (mm != n);
    p    = (dv <= 1) ? t : (2 * t) / (dv + 1);
    expv = act ? (mm * p) / n : p;
    derr = ((dinv & 255) != ((~n) & 255)) ? 1 : 0;
    @(negedge clk);
    cfg_div = DIV_W'(dv); cfg_mode = 2'(md); cfg_m = MND_W'(mm);
    cfg_n_inv = MND_W'(ninv); cfg_d_inv = MND_W'(dinv); cfg_load = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_load = 1'b0;
    check({tag, " R7 quiet after load R10"}, int'(pulse_o), 0);
    check({tag, " R9 d check"}, int'(d_err_o), derr);
    cnt = 0;
    for (int i = 0; i < t; i++) begin
      @(posedge clk); @(negedge clk);
      cnt += int'(pulse_o);
    end
    check({tag, " count"}, cnt, expv);
  endtask

  task automatic test_hold();
    int cnt;
    run_case("R2 base", 0, 0, 0, 255, 0, 10);
    @(negedge clk);
    cfg_div = 5'd9; cfg_mode = 2'd1; cfg_m = 8'd1; cfg_n_inv = 8'hF0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      cnt += int'(pulse_o);
    end
    check("R7 inputs ignored without load", cnt, 20);
  endtask

  initial begin
    test_reset();
    run_case("R2 div0", 0, 0, 0, 255, 0, 20);
    run_case("R2 div1", 1, 0, 0, 255, 0, 20);
    run_case("R3 div2 half", 2, 0, 0, 255, 0, 30);
    run_case("R3 div4", 4, 0, 0, 255, 0, 25);
    run_case("R3 div5 odd", 5, 0, 0, 255, 0, 31);
    run_case("R3 div31 max", 31, 0, 0, 255, 0, 64);
    run_case("R5 R8 m3 n7", 0, 1, 3, 8'hFB, 8'hF8, 70);
    run_case("R5 m3 n7 partial", 0, 1, 3, 8'hFB, 8'hF8, 10);
    run_case("R4 R5 m1 n2 div2", 2, 2, 1, 8'hFE, 8'hFD, 30);
    run_case("R5 m0 n3 silent", 0, 1, 0, 8'hFC, 8'h00, 20);
    run_case("R4 R8 wide n510", 0, 3, 255, 8'h00, 8'h01, 1020);
    run_case("R6 m eq n", 3, 1, 5, 8'hFF, 8'h00, 20);
    run_case("R6 mode0", 2, 0, 1, 8'hF9, 8'h00, 30);
    run_case("R6 n zero", 0, 1, 0, 8'hFF, 8'hFF, 15);
    test_hold();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule